// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator with Indirect Block Access

This block gathers a wide vector of interrupt inputs into a single summary interrupt line. Inputs are organised in groups of eight (a block), and blocks are organised in groups of eight (a master). Every input first crosses a two-flop synchronizer. It then passes through its own trigger cell, which can detect a rising edge, a falling edge, both edges, an active-high level or an active-low level. A hit sets a pending latch, which stays set until software clears it.

Software reaches the block over a simple 8-bit register bus with combinational read data. A small window of nine registers starts at a base address. A root register and four master-status registers give a summary tree. A block-select register then opens one block, so that its pending bits and its synchronized live levels can be read. A single configuration byte written to the same window sets the trigger mode and the masks of one input in the selected block, and can clear that input's pending latch. The input count is a parameter and must be a multiple of eight, at most 256.

Top module: `irq_tree_agg`

## Requirements
- R1: After reset every input is in edge mode with both masks set, every pending latch is 0, block select reads 0, the root and master registers read 0, and irq_out is 0.
- R2: Register offsets from REG_BASE (default 0x1BB) are: 0 root, 1..4 master status 0..3, 5 block select (read/write), 6 pending status of the selected block, 7 configuration (write-only, reads 0), 8 live status of the selected block. Any other address reads 0.
- R3: A configuration byte takes effect only when bit 7 is 1. Bits 6:4 give the input index inside the selected block, bit 3 clears that input's pending latch, bit 2 is the rise/high mask, bit 1 is the fall/low mask and bit 0 selects level mode. A byte with bit 7 at 0 changes nothing.
- R4: In edge mode, a cleared rise mask lets a 0-to-1 transition of the synchronized input set pending. A cleared fall mask lets a 1-to-0 transition set it. Both edges may be enabled together.
- R5: In level mode, a cleared rise/high mask makes a high input active, and a cleared fall/low mask makes a low input active. While the input is active, pending is set, and it is set again after a clear if the level is still present.
- R6: In edge mode a pending latch holds with no further input activity until a configuration write with bit 3 set addresses it.
- R7: With both masks set, no new pending event is recorded. A latch that is already set still reads 1 in pending status, but it does not reach the master, root or irq_out.
- R8: Master m status bit i is 1 exactly when block m*8+i has a pending input that is not fully masked. Root bit m+1 is 1 when master m status is nonzero, root bit 0 is always 0, and irq_out is the OR of the root master bits.
- R9: The live-status register returns the synchronized levels of the eight inputs of the selected block, bit i being input block*8+i. The pending-status register uses the same bit order.
- R10: When block select holds a number at or above the block count, the pending and live status read 0 and configuration writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq_in | input | N_IN | Raw interrupt inputs |
| irq_out | output | 1 | Summary interrupt |

## Verification
The hardest case to reach from the ports is a configuration write that lands on a latch whose trigger state changes in that same write. Examples are a level-mode input cleared while its level is still active, and an input switched into level mode while its active level is already present. Here the old setting and the new setting both decide the next pending value. The stimulus reaches these cases with random configuration bytes at random block and index choices, mixed with random input flips. Every pending, master and root value is compared against a bench model that applies the old trigger setting for the write cycle and the new one after it. Directed sequences add the level re-assertion after a clear, the ignored strobe-less write, and the out-of-range block select, whose index would alias an existing block if it were truncated.

// File: rtl/intagg_pkg.sv
`timescale 1ns/1ps
package intagg_pkg;

    localparam int OFF_ROOT  = 0;
    localparam int OFF_MST0  = 1;
    localparam int OFF_BSEL  = 5;
    localparam int OFF_PEND  = 6;
    localparam int OFF_CFG   = 7;
    localparam int OFF_LIVE  = 8;
    localparam int N_OFFS    = 9;
    localparam int MAX_MST   = 4;
    localparam int GRP       = 8;

    // Configuration byte as it arrives on the bus.
    typedef struct packed {
        logic       strobe;
        logic [2:0] idx;
        logic       clr;
        logic       mask_hi;
        logic       mask_lo;
        logic       lvl;
    } cfg_byte_t;

    // Trigger setting held per input.
    typedef struct packed {
        logic lvl;
        logic mask_hi;
        logic mask_lo;
    } trig_cfg_t;

    localparam trig_cfg_t TRIG_RESET = '{lvl: 1'b0, mask_hi: 1'b1, mask_lo: 1'b1};

    function automatic logic trig_hit(trig_cfg_t c, logic now, logic prev);
        if (c.lvl)
            return (!c.mask_hi && now) || (!c.mask_lo && !now);
        else
            return (!c.mask_hi && now && !prev) || (!c.mask_lo && !now && prev);
    endfunction

    function automatic logic fully_masked(trig_cfg_t c);
        return c.mask_hi && c.mask_lo;
    endfunction

endpackage

// File: rtl/agg_sync.sv
`timescale 1ns/1ps
module agg_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/agg_cell.sv
`timescale 1ns/1ps
module agg_cell
    import intagg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_in,
    input  logic      we,
    input  trig_cfg_t wcfg,
    input  logic      wclr,
    output logic      pend,
    output logic      act
);
    trig_cfg_t cfg;
    logic      prev;
    logic      hit;

    assign hit = trig_hit(cfg, lvl_in, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= TRIG_RESET;
            prev <= 1'b0;
            pend <= 1'b0;
        end else begin
            prev <= lvl_in;
            if (we) cfg <= wcfg;
            pend <= (pend && !(we && wclr)) || hit;
        end
    end

    assign act = pend && !fully_masked(cfg);

    // R3: setting only moves on an accepted write
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg));

    // R6: a latch survives every cycle without an addressed clear
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (pend && !(we && wclr)) |=> pend);

    // R7: a fully masked input records nothing new
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!pend && cfg.mask_hi && cfg.mask_lo) |=> !pend);
endmodule

// File: rtl/agg_tree.sv
`timescale 1ns/1ps
module agg_tree
    import intagg_pkg::*;
#(
    parameter int N_BLK = 8
) (
    input  logic [N_BLK*GRP-1:0]     act,
    output logic [MAX_MST*GRP-1:0]   mst,
    output logic [7:0]               root,
    output logic                     irq
);
    logic [MAX_MST-1:0] mst_nz;

    for (genvar b = 0; b < MAX_MST*GRP; b++) begin : g_blk
        if (b < N_BLK) begin : g_live
            assign mst[b] = |act[b*GRP +: GRP];
        end else begin : g_none
            assign mst[b] = 1'b0;
        end
    end

    for (genvar m = 0; m < MAX_MST; m++) begin : g_mst
        assign mst_nz[m] = |mst[m*GRP +: GRP];
    end

    assign root = {3'b000, mst_nz, 1'b0};
    assign irq  = |mst_nz;
endmodule

// File: rtl/irq_tree_agg.sv
`timescale 1ns/1ps
module irq_tree_agg
    import intagg_pkg::*;
#(
    parameter int                N_IN     = 64,
    parameter int                ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] REG_BASE = 'h1BB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [N_IN-1:0]   irq_in,
    output logic              irq_out
);
    localparam int N_BLK = N_IN / GRP;

    logic [7:0]             bsel;
    logic [ADDR_W-1:0]      off;
    logic                   hit;
    logic                   bsel_ok;
    logic                   cfg_go;
    cfg_byte_t              wb;
    trig_cfg_t              wcfg;
    logic [N_IN-1:0]        s_in;
    logic [N_IN-1:0]        pend;
    logic [N_IN-1:0]        act;
    logic [7:0]             sel_pend;
    logic [7:0]             sel_live;
    logic [MAX_MST*GRP-1:0] mst;
    logic [7:0]             root;

    assign off     = reg_addr - REG_BASE;
    assign hit     = (reg_addr >= REG_BASE) && (off < ADDR_W'(N_OFFS));
    assign bsel_ok = bsel < 8'(N_BLK);
    assign wb      = cfg_byte_t'(reg_wdata);
    assign wcfg    = '{lvl: wb.lvl, mask_hi: wb.mask_hi, mask_lo: wb.mask_lo};
    assign cfg_go  = reg_wr && hit && (off == ADDR_W'(OFF_CFG)) && wb.strobe && bsel_ok;

    always_ff @(posedge clk) begin
        if (rst) bsel <= '0;
        else if (reg_wr && hit && off == ADDR_W'(OFF_BSEL)) bsel <= reg_wdata;
    end

    agg_sync #(.W(N_IN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (s_in)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_cell
        agg_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .lvl_in (s_in[i]),
            .we     (cfg_go && bsel == 8'(i / GRP) && wb.idx == 3'(i % GRP)),
            .wcfg   (wcfg),
            .wclr   (wb.clr),
            .pend   (pend[i]),
            .act    (act[i])
        );
    end

    always_comb begin
        sel_pend = '0;
        sel_live = '0;
        for (int b = 0; b < N_BLK; b++) begin
            if (bsel == 8'(b)) begin
                sel_pend = pend[b*GRP +: GRP];
                sel_live = s_in[b*GRP +: GRP];
            end
        end
    end

    agg_tree #(.N_BLK(N_BLK)) u_tree (
        .act  (act),
        .mst  (mst),
        .root (root),
        .irq  (irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (off[3:0])
                4'd0:    reg_rdata = root;
                4'd1:    reg_rdata = mst[0*GRP +: GRP];
                4'd2:    reg_rdata = mst[1*GRP +: GRP];
                4'd3:    reg_rdata = mst[2*GRP +: GRP];
                4'd4:    reg_rdata = mst[3*GRP +: GRP];
                4'd5:    reg_rdata = bsel;
                4'd6:    reg_rdata = sel_pend;
                4'd8:    reg_rdata = sel_live;
                default: reg_rdata = '0;
            endcase
        end
    end

    // R8: the summary line needs at least one unmasked pending input
    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        !(|act) |-> !irq_out);

    // R10: an out-of-range select never exposes status
    p_oob_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !bsel_ok |-> (sel_pend == 8'h00 && sel_live == 8'h00));
endmodule

// File: tb/tb_irq_tree_agg.sv
`timescale 1ns/1ps
module tb_irq_tree_agg;
    localparam int N    = 64;
    localparam int NB   = N / 8;
    localparam int AW   = 10;
    localparam logic [AW-1:0] BASE = 10'h1BB;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] reg_addr;
    logic          reg_wr;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic [N-1:0]  irq_in;
    logic          irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [N-1:0] m_lvl, m_mhi, m_mlo, m_pend, cur_in;

    always #2.5 clk = ~clk;

    irq_tree_agg #(.N_IN(N), .ADDR_W(AW), .REG_BASE(BASE)) dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic lvl_active(logic l, logic mh, logic ml, logic v);
        return l && ((!mh && v) || (!ml && !v));
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic wr(int off, logic [7:0] d);
        @(negedge clk);
        reg_addr  = BASE + AW'(off);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_raw(logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd(int off, output logic [7:0] d);
        rd_raw(BASE + AW'(off), d);
    endtask

    task automatic set_inputs(logic [N-1:0] nv);
        for (int i = 0; i < N; i++) begin
            if (m_lvl[i]) begin
                if (lvl_active(1'b1, m_mhi[i], m_mlo[i], nv[i])) m_pend[i] = 1'b1;
            end else begin
                if (!cur_in[i] && nv[i] && !m_mhi[i]) m_pend[i] = 1'b1;
                if (cur_in[i] && !nv[i] && !m_mlo[i]) m_pend[i] = 1'b1;
            end
        end
        @(negedge clk);
        irq_in = nv;
        cur_in = nv;
        settle();
    endtask

    task automatic cfg(int blk, int idx, logic [7:0] b);
        int i;
        wr(5, 8'(blk));
        wr(7, (b & 8'h8F) | (8'(idx) << 4));
        if (b[7] && blk < NB) begin
            i = blk * 8 + idx;
            m_pend[i] = (m_pend[i] && !b[3]) ||
                        lvl_active(m_lvl[i], m_mhi[i], m_mlo[i], cur_in[i]);
            m_lvl[i] = b[0];
            m_mlo[i] = b[1];
            m_mhi[i] = b[2];
            if (lvl_active(m_lvl[i], m_mhi[i], m_mlo[i], cur_in[i])) m_pend[i] = 1'b1;
        end
        settle();
    endtask

    task automatic check_block(string req, int b);
        logic [7:0] d;
        wr(5, 8'(b));
        rd(6, d);
        chk(req, d, m_pend[b*8 +: 8]);
    endtask

    task automatic check_tree(string req);
        logic [7:0] d, root;
        logic [7:0] ms;
        root = 8'h00;
        for (int m = 0; m < 4; m++) begin
            ms = 8'h00;
            for (int k = 0; k < 8; k++) begin
                if (m*8 + k < NB)
                    ms[k] = |(m_pend[(m*8+k)*8 +: 8] & ~(m_mhi[(m*8+k)*8 +: 8] & m_mlo[(m*8+k)*8 +: 8]));
            end
            rd(1 + m, d);
            chk(req, d, ms);
            root[m+1] = |ms;
        end
        rd(0, d);
        chk(req, d, root);
        chk(req, {7'b0, irq_out}, {7'b0, |root});
    endtask

    task automatic check_all(string req);
        for (int b = 0; b < NB; b++) check_block(req, b);
        check_tree(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [N-1:0] v;
        void'($urandom(32'd2024));
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; irq_in = '0;
        cur_in = '0; m_pend = '0; m_lvl = '0; m_mhi = '1; m_mlo = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, d); chk("R1 root", d, 8'h00);
        rd(5, d); chk("R1 bsel", d, 8'h00);
        rd(6, d); chk("R1 pend", d, 8'h00);
        rd(1, d); chk("R1 mst0", d, 8'h00);
        chk("R1 irq", {7'b0, irq_out}, 8'h00);

        // R2 register map
        wr(5, 8'h05); rd(5, d); chk("R2 bsel readback", d, 8'h05);
        rd(7, d); chk("R2 cfg reads zero", d, 8'h00);
        rd_raw(BASE + 10'd9, d); chk("R2 past window", d, 8'h00);
        rd_raw(BASE - 10'd1, d); chk("R2 below window", d, 8'h00);

        // R9 live status, all masked so no pending
        v = cur_in; v[2*8 +: 8] = 8'hA5; set_inputs(v);
        wr(5, 8'h02); rd(8, d); chk("R9 live", d, 8'hA5);
        check_block("R9 masked inputs stay idle", 2);
        v[2*8 +: 8] = 8'h00; set_inputs(v);

        // R3 strobe-less write ignored
        cfg(2, 1, 8'h00);
        v = cur_in; v[17] = 1'b1; set_inputs(v);
        check_block("R3 no strobe", 2);
        v[17] = 1'b0; set_inputs(v);

        // R4 rising only, then both edges
        cfg(2, 1, 8'h82);
        v = cur_in; v[17] = 1'b1; set_inputs(v);
        check_block("R4 rise", 2); check_tree("R8 tree after rise");
        cfg(2, 1, 8'h8A);
        v[17] = 1'b0; set_inputs(v);
        check_block("R4 fall masked", 2);
        cfg(2, 1, 8'h80);
        v[17] = 1'b1; set_inputs(v);
        cfg(2, 1, 8'h88);
        v[17] = 1'b0; set_inputs(v);
        check_block("R4 fall enabled", 2);

        // R6 latch holds
        repeat (20) @(negedge clk);
        check_block("R6 hold", 2);

        // R7 fully masked keeps latch but hides it
        cfg(2, 1, 8'h86);
        check_block("R7 latch visible", 2);
        check_tree("R7 hidden from tree");

        // R5 level high with re-assert, then active low
        cfg(0, 3, 8'h83);
        v = cur_in; v[3] = 1'b1; set_inputs(v);
        cfg(0, 3, 8'h8B);
        check_block("R5 reassert after clear", 0);
        v[3] = 1'b0; set_inputs(v);
        cfg(0, 3, 8'h8B);
        check_block("R5 cleared when idle", 0);
        cfg(0, 4, 8'h85);
        check_block("R5 active low", 0);
        check_tree("R8 tree level");

        // R10 out-of-range select
        wr(5, 8'(NB)); rd(6, d); chk("R10 pend oob", d, 8'h00);
        rd(8, d); chk("R10 live oob", d, 8'h00);
        cfg(NB, 0, 8'h80);
        v = cur_in; v[0] = 1'b1; set_inputs(v);
        check_block("R10 no alias", 0);

        // Random mix, R3 R4 R5 R8 coverage
        for (int it = 0; it < 150; it++) begin
            if ($urandom_range(1, 0) == 0) begin
                logic [7:0] b;
                b = 8'($urandom());
                if ($urandom_range(4, 0) != 0) b[7] = 1'b1;
                cfg($urandom_range(NB, 0), $urandom_range(7, 0), b);
            end else begin
                v = cur_in;
                for (int k = 0; k < 4; k++) v[$urandom_range(N-1, 0)] ^= 1'b1;
                set_inputs(v);
            end
            if (it % 10 == 9) check_all("R8 random");
        end
        check_all("R5 random final");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule